// File: doc/BRIEF.md
# SD/MMC Command Line Engine

This block drives the command line of an SD/MMC card for one command at a time and captures the card's reply. Software first writes the 48-bit outgoing frame into three 16-bit command words, with the CRC and end bit already in place. It then writes a launch word. The launch word carries a sequence toggle, the expected reply format and the command kind. The engine shifts the frame out MSB first, one bit per bus-clock enable. It then watches the line for the card's start bit within a window that software can program. It collects a 48-bit or 136-bit reply and checks the CRC7 of short replies.

A status word tells software several things: whether the engine is free, whether a reply arrived, whether the wait window ran out, and whether a reply failed its CRC. The status word also echoes the toggle of the last command that finished. A poll loop therefore knows when it is looking at fresh results. A level interrupt can be enabled for completion. Bus-clock generation, the data lines and busy signalling belong to other blocks. The engine only receives a one-cycle tick per bus clock.

Top module: `sdcmd_host`

## Requirements
- R1: After reset the status word (0x20) reads 0x4000, the wait register (0x40) reads 0x0FFF, `irq` is low, `cmd_oe` is low and `cmd_out` is high.
- R2: An accepted launch drives the 48 bits {word 0x04, word 0x02, word 0x00} MSB first on `cmd_out`, one bit per tick, with `cmd_oe` high. Bit k is present before the k-th tick. From the tick after the last bit, `cmd_oe` is low and `cmd_out` is high.
- R3: Launch word at 0x06 uses these fields: bit 12 is the toggle, bits 10:8 are the reply format, and bits 7:6 are the command kind. A kind of 0 expects no reply. Such a command completes right after its last frame bit and leaves status bits 9, 5 and 1 clear.
- R4: Status bit 14 (idle) is low from an accepted launch until completion. Status bit 15 keeps the previous command's toggle until completion, and then takes the new toggle.
- R5: A write to 0x06 while bit 14 is low is ignored. The running command goes on with its own format, kind and toggle.
- R6: The wait window is W = 16 × (wait register) ticks after the last frame bit. A 0 on `cmd_in` at a wait tick with index below W starts the reply. At wait tick index W, the engine sets status bit 5, goes idle, and leaves the reply words unchanged. A start bit at that same tick loses to the timeout.
- R7: A short reply is 48 bits, start bit included. Word 0x10 holds the last 16 received bits, 0x12 the 16 bits before those, and 0x14 the first 16. Words 0x16–0x1E read 0, and status bit 9 is set.
- R8: Format 2 is a 136-bit reply. The last 128 received bits fill words 0x10 (latest) through 0x1E (earliest), and no CRC check applies.
- R9: Formats 0, 1, 4 and 5 check CRC7 (x^7+x^3+1) over the first 40 reply bits against reply bits 7:1. On a mismatch, status bit 1 is set and bit 9 is clear. Format 3 is never checked.
- R10: With control (0x30) bit 0 set, a CRC mismatch is accepted: bit 9 is set and bit 1 is clear.
- R11: With control bit 1 set at completion, `irq` goes high and stays high until the next accepted launch. With control bit 1 clear, `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 7 | Register byte offset |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data (combinational on addr) |
| clk_en | input | 1 | One-cycle tick per bus clock |
| cmd_in | input | 1 | Command line as seen from the card |
| cmd_out | output | 1 | Command line value driven by the engine |
| cmd_oe | output | 1 | Drive enable for the command line |
| irq | output | 1 | Completion interrupt, level |

## Verification
Two functions can land on the same tick: expiry of the wait window and detection of the reply's start bit. The bench sets the wait register to 1 (W = 16) and runs two cases. In the first, it holds the line high for 15 wait ticks and pulls it low on tick index 15; this must give a normal reply with bit 9. In the second, it holds the line high for 16 ticks and pulls it low on tick index 16; this must give status bit 5 with unchanged reply words. A second overlap is a launch write that arrives while a command is still running. The bench writes a flipped toggle and kind in the middle of the frame. It then judges the final status echo and reply handling against the original launch only.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int FRAME_W  = 48;   // short frame / short reply length
  localparam int LONG_W   = 136;  // long reply length on the wire
  localparam int KEEP_W   = 128;  // reply bits retained
  localparam int CRC_SPAN = 40;   // reply bits covered by CRC7
  localparam int CRC_W    = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;
  localparam int REG_W    = 16;

  localparam int A_CMD0  = 'h00;
  localparam int A_CMD1  = 'h02;
  localparam int A_CMD2  = 'h04;
  localparam int A_FIRE  = 'h06;
  localparam int A_RSPLO = 'h10;
  localparam int A_RSPHI = 'h1E;
  localparam int A_STAT  = 'h20;
  localparam int A_CTRL  = 'h30;
  localparam int A_WAIT  = 'h40;

  typedef enum logic [2:0] {ST_IDLE, ST_TX, ST_WAIT, ST_RX, ST_DONE} eng_state_t;

  typedef struct packed {
    logic resp_seen;
    logic no_resp;
    logic crc_bad;
  } eng_result_t;
endpackage

// File: rtl/sdcmd_rst_sync.sv
module sdcmd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7
  import sdcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  logic [CRC_W-1:0] crc_q, crc_d;
  logic             fb;

  always_comb begin
    fb    = din ^ crc_q[CRC_W-1];
    crc_d = crc_q;
    if (clr)        crc_d = '0;
    else if (shift) crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int TMO_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic               want_rsp,
  input  logic               long_rsp,
  input  logic               chk_crc,
  input  logic [TMO_W-1:0]   tmo_units,
  input  logic               cmd_in,
  output logic               cmd_out,
  output logic               cmd_oe,
  output logic               busy,
  output logic               done,
  output eng_result_t        result,
  output logic [KEEP_W-1:0]  rx_bits
);
  localparam int CNT_W  = $clog2(LONG_W + 1);
  localparam int WAIT_W = TMO_W + 4;

  eng_state_t         st_q, st_d;
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d, rx_len;
  logic [WAIT_W-1:0]  wcnt_q, wcnt_d, limit;
  logic [KEEP_W-1:0]  rx_q, rx_d;
  logic               rsp_q, rsp_d, tmo_q, tmo_d;
  logic               crc_en, crc_clr;
  logic [CRC_W-1:0]   crc_val;

  assign limit   = {tmo_units, 4'b0000};
  assign rx_len  = long_rsp ? CNT_W'(LONG_W) : CNT_W'(FRAME_W);
  assign crc_clr = start && (st_q == ST_IDLE);

  always_comb begin
    st_d = st_q; tx_d = tx_q; cnt_d = cnt_q; wcnt_d = wcnt_q;
    rx_d = rx_q; rsp_d = rsp_q; tmo_d = tmo_q; crc_en = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d = ST_TX; tx_d = frame; cnt_d = '0;
        rx_d = '0; rsp_d = 1'b0; tmo_d = 1'b0;
      end
      ST_TX: if (tick) begin
        tx_d  = {tx_q[FRAME_W-2:0], 1'b1};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(FRAME_W - 1)) begin
          cnt_d  = '0;
          wcnt_d = '0;
          st_d   = want_rsp ? ST_WAIT : ST_DONE;
        end
      end
      ST_WAIT: if (tick) begin
        if (wcnt_q == limit) begin
          tmo_d = 1'b1;
          st_d  = ST_DONE;
        end else if (!cmd_in) begin
          crc_en = 1'b1;
          rx_d   = {rx_q[KEEP_W-2:0], 1'b0};
          cnt_d  = CNT_W'(1);
          st_d   = ST_RX;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      ST_RX: if (tick) begin
        crc_en = (cnt_q < CNT_W'(CRC_SPAN));
        rx_d   = {rx_q[KEEP_W-2:0], cmd_in};
        cnt_d  = cnt_q + 1'b1;
        if (cnt_d == rx_len) begin
          rsp_d = 1'b1;
          st_d  = ST_DONE;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; tx_q <= '0; cnt_q <= '0; wcnt_q <= '0;
      rx_q <= '0; rsp_q <= 1'b0; tmo_q <= 1'b0;
    end else begin
      st_q <= st_d; tx_q <= tx_d; cnt_q <= cnt_d; wcnt_q <= wcnt_d;
      rx_q <= rx_d; rsp_q <= rsp_d; tmo_q <= tmo_d;
    end
  end

  sdcmd_crc7 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .shift (crc_en),
    .din   (cmd_in),
    .crc   (crc_val)
  );

  assign cmd_oe           = (st_q == ST_TX);
  assign cmd_out          = cmd_oe ? tx_q[FRAME_W-1] : 1'b1;
  assign busy             = (st_q != ST_IDLE);
  assign done             = (st_q == ST_DONE);
  assign result.resp_seen = rsp_q;
  assign result.no_resp   = tmo_q;
  assign result.crc_bad   = rsp_q && chk_crc && (crc_val != rx_q[CRC_W:1]);
  assign rx_bits          = rx_q;
endmodule

// File: rtl/sdcmd_host.sv
module sdcmd_host
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int TMO_W  = 12,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              clk_en,
  input  logic              cmd_in,
  output logic              cmd_out,
  output logic              cmd_oe,
  output logic              irq
);
  localparam int N_RSP = KEEP_W / REG_W;

  logic rst_s_n;
  logic [REG_W-1:0] cmd0_q, cmd0_d, cmd1_q, cmd1_d, cmd2_q, cmd2_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;
  logic [1:0]       ctrl_q, ctrl_d, ctype_q, ctype_d;
  logic [2:0]       rtype_q, rtype_d;
  logic tog_q, tog_d, stat_tog_q, stat_tog_d;
  logic stat_rrdy_q, stat_rrdy_d, stat_nrto_q, stat_nrto_d;
  logic stat_crc_q, stat_crc_d, irq_q, irq_d;
  logic [N_RSP-1:0][REG_W-1:0] resp_q, resp_d;

  logic fire_wr, fire_ok, eng_busy, eng_done, reject, in_rsp;
  eng_result_t       eng_res;
  logic [KEEP_W-1:0] eng_rx;

  sdcmd_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  assign fire_wr = wr_en && (addr == ADDR_W'(A_FIRE));
  assign fire_ok = fire_wr && !eng_busy;
  assign reject  = eng_res.crc_bad && !ctrl_q[0];

  sdcmd_engine #(.TMO_W(TMO_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .tick      (clk_en),
    .start     (fire_ok),
    .frame     ({cmd2_q, cmd1_q, cmd0_q}),
    .want_rsp  (ctype_q != 2'd0),
    .long_rsp  (rtype_q == 3'd2),
    .chk_crc   (rtype_q inside {3'd0, 3'd1, 3'd4, 3'd5}),
    .tmo_units (tmo_q),
    .cmd_in    (cmd_in),
    .cmd_out   (cmd_out),
    .cmd_oe    (cmd_oe),
    .busy      (eng_busy),
    .done      (eng_done),
    .result    (eng_res),
    .rx_bits   (eng_rx)
  );

  always_comb begin
    cmd0_d = cmd0_q; cmd1_d = cmd1_q; cmd2_d = cmd2_q;
    tmo_d = tmo_q; ctrl_d = ctrl_q; ctype_d = ctype_q; rtype_d = rtype_q;
    tog_d = tog_q; stat_tog_d = stat_tog_q; stat_rrdy_d = stat_rrdy_q;
    stat_nrto_d = stat_nrto_q; stat_crc_d = stat_crc_q; irq_d = irq_q;
    resp_d = resp_q;
    if (wr_en) begin
      if (addr == ADDR_W'(A_CMD0)) cmd0_d = wdata;
      if (addr == ADDR_W'(A_CMD1)) cmd1_d = wdata;
      if (addr == ADDR_W'(A_CMD2)) cmd2_d = wdata;
      if (addr == ADDR_W'(A_WAIT)) tmo_d  = wdata[TMO_W-1:0];
      if (addr == ADDR_W'(A_CTRL)) ctrl_d = wdata[1:0];
    end
    if (fire_ok) begin
      tog_d       = wdata[12];
      rtype_d     = wdata[10:8];
      ctype_d     = wdata[7:6];
      stat_rrdy_d = 1'b0;
      stat_nrto_d = 1'b0;
      stat_crc_d  = 1'b0;
      irq_d       = 1'b0;
    end
    if (eng_done) begin
      stat_tog_d  = tog_q;
      stat_rrdy_d = eng_res.resp_seen && !reject;
      stat_crc_d  = reject;
      stat_nrto_d = eng_res.no_resp;
      irq_d       = ctrl_q[1];
      if (eng_res.resp_seen)
        resp_d = (rtype_q == 3'd2) ? eng_rx : KEEP_W'(eng_rx[FRAME_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cmd0_q <= '0; cmd1_q <= '0; cmd2_q <= '0;
      tmo_q <= '1; ctrl_q <= '0; ctype_q <= '0; rtype_q <= '0;
      tog_q <= 1'b0; stat_tog_q <= 1'b0; stat_rrdy_q <= 1'b0;
      stat_nrto_q <= 1'b0; stat_crc_q <= 1'b0; irq_q <= 1'b0;
      resp_q <= '0;
    end else begin
      cmd0_q <= cmd0_d; cmd1_q <= cmd1_d; cmd2_q <= cmd2_d;
      tmo_q <= tmo_d; ctrl_q <= ctrl_d; ctype_q <= ctype_d; rtype_q <= rtype_d;
      tog_q <= tog_d; stat_tog_q <= stat_tog_d; stat_rrdy_q <= stat_rrdy_d;
      stat_nrto_q <= stat_nrto_d; stat_crc_q <= stat_crc_d; irq_q <= irq_d;
      resp_q <= resp_d;
    end
  end

  assign in_rsp = (addr >= ADDR_W'(A_RSPLO)) && (addr <= ADDR_W'(A_RSPHI)) && !addr[0];

  always_comb begin
    rdata = '0;
    if (in_rsp) rdata = resp_q[addr[3:1]];
    else if (addr == ADDR_W'(A_CMD0)) rdata = cmd0_q;
    else if (addr == ADDR_W'(A_CMD1)) rdata = cmd1_q;
    else if (addr == ADDR_W'(A_CMD2)) rdata = cmd2_q;
    else if (addr == ADDR_W'(A_WAIT)) rdata = REG_W'(tmo_q);
    else if (addr == ADDR_W'(A_CTRL)) rdata = REG_W'(ctrl_q);
    else if (addr == ADDR_W'(A_STAT))
      rdata = {stat_tog_q, !eng_busy, 4'b0, stat_rrdy_q, 3'b0,
               stat_nrto_q, 3'b0, stat_crc_q, 1'b0};
  end

  assign irq = irq_q;
endmodule

// File: rtl/sdcmd_host_chk.sv
module sdcmd_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fire_wr,
  input logic       fire_ok,
  input logic       eng_busy,
  input logic       eng_done,
  input logic       tog_q,
  input logic [2:0] rtype_q,
  input logic       stat_tog_q,
  input logic [1:0] ctrl_q,
  input logic       stat_rrdy_q,
  input logic       stat_crc_q,
  input logic       stat_nrto_q,
  input logic       irq
);
  p_launch_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_ok |=> eng_busy);

  p_busy_launch_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_wr && eng_busy) |=> ($stable(tog_q) && $stable(rtype_q)));

  p_echo_only_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_done |=> $stable(stat_tog_q));

  p_irq_needs_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ctrl_q[1]));

  p_crc_blocks_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_crc_q |-> !stat_rrdy_q);

  p_timeout_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_nrto_q |-> (!stat_rrdy_q && !stat_crc_q));
endmodule

bind sdcmd_host sdcmd_host_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fire_wr     (fire_wr),
  .fire_ok     (fire_ok),
  .eng_busy    (eng_busy),
  .eng_done    (eng_done),
  .tog_q       (tog_q),
  .rtype_q     (rtype_q),
  .stat_tog_q  (stat_tog_q),
  .ctrl_q      (ctrl_q),
  .stat_rrdy_q (stat_rrdy_q),
  .stat_crc_q  (stat_crc_q),
  .stat_nrto_q (stat_nrto_q),
  .irq         (irq)
);

// File: tb/sdcmd_host_bench.sv
module sdcmd_host_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, clk_en = 1'b0, cmd_in = 1'b1;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic cmd_out, cmd_oe, irq;

  always #4 clk = ~clk;

  sdcmd_host u_sdcmd_host (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .clk_en(clk_en), .cmd_in(cmd_in), .cmd_out(cmd_out),
    .cmd_oe(cmd_oe), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_rsp [8];
  logic tog_m = 1'b0;
  logic obs_out, obs_oe;

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_up();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic tick(input logic cin);
    @(negedge clk);
    obs_out = cmd_out; obs_oe = cmd_oe;
    cmd_in = cin; clk_en = 1'b1;
    @(negedge clk); clk_en = 1'b0;
  endtask

  function automatic logic [6:0] crc7_of(input logic [39:0] d);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic fb;
      fb = d[i] ^ c[6];
      c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  function automatic logic [47:0] mk_cmd(input logic [5:0] idx, input logic [31:0] arg);
    return {2'b01, idx, arg, crc7_of({2'b01, idx, arg}), 1'b1};
  endfunction

  function automatic logic [47:0] mk_rsp(input logic [5:0] idx, input logic [31:0] arg, input bit bad);
    logic [6:0] c;
    c = crc7_of({2'b00, idx, arg}) ^ (bad ? 7'h01 : 7'h00);
    return {2'b00, idx, arg, c, 1'b1};
  endfunction

  function automatic logic [15:0] mk_fire(input logic t, input logic [2:0] rt, input logic [1:0] ct);
    return {3'b000, t, 1'b0, rt, ct, 2'b00, 4'hA};
  endfunction

  function automatic logic [15:0] exp_stat(input logic t, input logic idle, input logic rrdy,
                                           input logic nrto, input logic crc);
    return {t, idle, 4'b0, rrdy, 3'b0, nrto, 3'b0, crc, 1'b0};
  endfunction

  // One whole command: program, launch, shift, answer, judge.
  task automatic run(input logic [47:0] frame, input logic [2:0] rt, input logic [1:0] ct,
                     input int delay, input int nbits, input logic [135:0] rsp,
                     input logic [11:0] tmo, input logic [1:0] ctrl, input bit mid_fire);
    logic [15:0] d, fire;
    int tx_err = 0;
    bit got, crc_flag, tmo_hit;
    logic tog_new;
    tog_new = ~tog_m;
    fire = mk_fire(tog_new, rt, ct);
    wr(7'h40, {4'h0, tmo});
    wr(7'h30, {14'h0, ctrl});
    wr(7'h04, frame[47:32]);
    wr(7'h02, frame[31:16]);
    wr(7'h00, frame[15:0]);
    wr(7'h06, fire);
    for (int i = 0; i < 48; i++) begin
      if (mid_fire && i == 10) wr(7'h06, fire ^ 16'h10C0);
      if (i == 20) begin
        rd(7'h20, d);
        chk("R4 busy status keeps old toggle", d, exp_stat(tog_m, 1'b0, 1'b0, 1'b0, 1'b0));
      end
      tick(1'b1);
      if (!obs_oe || obs_out !== frame[47-i]) tx_err++;
    end
    chk("R2 frame bits on cmd_out", tx_err, 0);
    tmo_hit = 1'b0; got = 1'b0; crc_flag = 1'b0;
    if (ct != 2'd0) begin
      for (int k = 0; k < delay; k++) begin
        tick(1'b1);
        if (k == 0) chk("R2 line released after frame", {obs_oe, obs_out}, 2'b01);
      end
      for (int k = 0; k < nbits; k++) tick(rsp[nbits-1-k]);
      if (delay >= 16 * int'(tmo)) tmo_hit = 1'b1;
      else got = 1'b1;
    end
    if (got) begin
      if (rt inside {3'd0, 3'd1, 3'd4, 3'd5} && !ctrl[0])
        crc_flag = (crc7_of(rsp[47:8]) != rsp[7:1]);
      for (int w = 0; w < 8; w++)
        exp_rsp[w] = (rt == 3'd2) ? rsp[16*w +: 16] : ((w < 3) ? rsp[16*w +: 16] : 16'h0);
    end
    tog_m = tog_new;
    rd(7'h20, d);
    chk("R3/R6/R9/R10 final status", d, exp_stat(tog_m, 1'b1, got && !crc_flag, tmo_hit, crc_flag));
    chk("R11 irq level", irq, ctrl[1]);
    for (int w = 0; w < 8; w++) begin
      rd(7'(16 + 2*w), d);
      chk("R7/R8 reply word", d, exp_rsp[w]);
    end
  endtask

  initial begin
    logic [15:0] d;
    logic [135:0] lr;
    void'($urandom(32'd20240611));
    for (int w = 0; w < 8; w++) exp_rsp[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(7'h20, d); chk("R1 status after reset", d, 16'h4000);
    rd(7'h40, d); chk("R1 wait register after reset", d, 16'h0FFF);
    chk("R1 irq after reset", irq, 1'b0);
    chk("R1 line idle after reset", {cmd_oe, cmd_out}, 2'b01);

    // R7 R9 R11: good short reply, irq enabled
    run(mk_cmd(6'd17, 32'h1234_5678), 3'd0, 2'd3, 3, 48,
        136'(mk_rsp(6'd17, 32'h0000_0900, 1'b0)), 12'd4, 2'b10, 1'b0);
    // R9 mismatch rejected, R11 irq off
    run(mk_cmd(6'd13, 32'hA5A5_0001), 3'd1, 2'd2, 0, 48,
        136'(mk_rsp(6'd13, 32'hDEAD_BEEF, 1'b1)), 12'd4, 2'b00, 1'b0);
    // R10 rejection disabled
    run(mk_cmd(6'd7, 32'h0), 3'd5, 2'd2, 5, 48,
        136'(mk_rsp(6'd7, 32'h0BAD_F00D, 1'b1)), 12'd4, 2'b01, 1'b0);
    // R9 format 3 not checked
    run(mk_cmd(6'd41, 32'h40FF_8000), 3'd3, 2'd1, 2, 48,
        136'(mk_rsp(6'd63, 32'hFFFF_FFFF, 1'b1)), 12'd4, 2'b00, 1'b0);
    // R8 long reply
    lr = {$urandom, $urandom, $urandom, $urandom, 8'h3F};
    lr[135] = 1'b0;
    run(mk_cmd(6'd2, 32'h0), 3'd2, 2'd1, 4, 136, lr, 12'd4, 2'b10, 1'b0);
    // R6 timeout, reply words untouched
    run(mk_cmd(6'd55, 32'h0), 3'd0, 2'd3, 17, 0, '0, 12'd1, 2'b10, 1'b0);
    // R6 start bit on last tick inside the window
    run(mk_cmd(6'd9, 32'h1), 3'd0, 2'd3, 15, 48,
        136'(mk_rsp(6'd9, 32'h0000_0F00, 1'b0)), 12'd1, 2'b00, 1'b0);
    // R6 start bit on the expiry tick: timeout wins
    run(mk_cmd(6'd9, 32'h2), 3'd0, 2'd3, 16, 1, '0, 12'd1, 2'b00, 1'b0);
    // R3 no-reply kind
    run(mk_cmd(6'd0, 32'h0), 3'd0, 2'd0, 0, 0, '0, 12'd4, 2'b10, 1'b0);
    // R5 launch during busy ignored
    run(mk_cmd(6'd18, 32'hCAFE_0000), 3'd1, 2'd3, 6, 48,
        136'(mk_rsp(6'd18, 32'h1357_9BDF, 1'b0)), 12'd4, 2'b00, 1'b1);

    // Random mix
    for (int it = 0; it < 30; it++) begin
      logic [2:0] rt;
      logic [1:0] ct;
      logic [5:0] idx;
      logic [31:0] arg;
      case ($urandom % 5)
        0: rt = 3'd0; 1: rt = 3'd1; 2: rt = 3'd3; 3: rt = 3'd4; default: rt = 3'd5;
      endcase
      ct  = (it % 7 == 6) ? 2'd0 : 2'(1 + $urandom % 3);
      idx = 6'($urandom);
      arg = $urandom;
      run(mk_cmd(idx, arg), rt, ct, int'($urandom % 20), 48,
          136'(mk_rsp(6'($urandom), $urandom, ($urandom % 3) == 0)),
          12'(2 + $urandom % 3), 2'($urandom), 1'b0);
    end
    finish_up();
  end
endmodule